// File: doc/BRIEF.md
# Parallel Diagonal-Gaussian Log-Likelihood Array

This block scores a group of consecutive speech feature frames against one hidden-Markov-model state whose output density is a diagonal Gaussian. A group of lanes (eight by default) runs in lockstep. Lane k receives its own coefficient of frame t+k each cycle. All lanes share the mean and inverse-variance weight for that coefficient index and the per-state constant, so one parameter fetch serves every frame in the group.

Each accepted coefficient goes through a fixed chain. The lane first takes a 16-bit signed difference from the mean. It squares that difference and rescales the square to 26 bits. It multiplies the result by the 16-bit weight and adds the product into a 52-bit signed accumulator. After the last coefficient of the frame, each lane subtracts its accumulated distance from the state constant. The output is log b_j(o_t) as a 52-bit signed value.

A small controller sequences a frame. A start pulse opens it. The controller then counts 26 accepted coefficients, which need not arrive back to back, and raises a done pulse for one cycle. Each lane also keeps a sticky overflow flag for arithmetic that left its range.

Top module: `gll_array`

The controller has three states:
- ST_IDLE waits for a start.
- ST_ACCUM accepts coefficients.
- ST_DONE lasts one cycle and drives the done flag.

It has these transitions:
- IDLE→ACCUM on start.
- ACCUM→ACCUM on start, which restarts the frame.
- ACCUM→DONE when the 26th coefficient is accepted.
- DONE→ACCUM on start.
- DONE→IDLE otherwise.

## Requirements
- R1: After reset, done is 0, every overflow bit is 0 and every lane's log-probability is 0.
- R2: For each accepted coefficient, a lane adds floor(((x−μ) wrapped to 16-bit signed)² / 32) × w to its sum. Here x is the lane's coefficient, μ is the signed mean and w is the unsigned weight. The frame result is the sign-extended state constant minus the sum of 26 such terms, as 52-bit two's complement.
- R3: done is high for exactly one cycle. That cycle follows the clock edge that accepts the 26th coefficient. The log-probability outputs change only at that edge and hold until the next completed frame.
- R4: A cycle with valid low is not counted, so the coefficients of a frame may arrive with gaps.
- R5: start clears the count and the accumulators, even in the middle of a frame. A coefficient presented in the same cycle as start is ignored, and no done follows a cycle with start.
- R6: valid outside a frame (before any start, or after done without a new start) is ignored. It produces no done and no change to the outputs.
- R7: A lane's overflow bit sets when x−μ falls outside the 16-bit signed range, or when its 52-bit accumulator or final subtraction would leave the signed range. The bit stays set until start, which clears it.
- R8: Lane k takes its coefficient from feat bits [16k+15:16k] and drives logp bits [52k+51:52k] and ovf bit k. All lanes use the same mean, weight and state constant.
- R9: The state constant is captured in the start cycle. Later changes to the gconst input do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a new frame and clears the lanes |
| valid | input | 1 | Coefficient inputs hold an accepted coefficient |
| feat | input | 128 | One signed 16-bit coefficient per lane |
| mean | input | 16 | Signed mean for the current coefficient index |
| ivar | input | 16 | Unsigned inverse-variance weight |
| gconst | input | 16 | Signed per-state constant, sampled on start |
| logp | output | 416 | One signed 52-bit log-probability per lane |
| done | output | 1 | One-cycle pulse: the results are new |
| ovf | output | 8 | Sticky overflow flag per lane |

## Verification
The bench drives frames with gaps between coefficients. A counter that counted idle cycles would finish early, and its scores would not match the scoreboard. The bench aborts a frame with a start that arrives alongside a valid coefficient. A design that kept the aborted partial sum, or took that coefficient, would report a distance that is off. A coefficient-mean pair whose difference leaves the 16-bit range checks three things: the lane must set its overflow bit, it must keep the wrapped difference, and no other lane may flag. The bench also presents valid coefficients with no frame open and changes gconst in the middle of a frame, which would expose a spurious done or a late capture of the constant.

// File: rtl/gll_pkg.sv
package gll_pkg;
    localparam int GLL_COEF_W   = 16;
    localparam int GLL_N_COEF   = 26;
    localparam int GLL_LANES    = 8;
    localparam int GLL_ACC_W    = 52;
    localparam int GLL_SQ_SHIFT = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_DONE  = 2'd2
    } gll_state_e;
endpackage

// File: rtl/gll_ctrl.sv
module gll_ctrl
    import gll_pkg::*;
#(
    parameter int N_COEF = GLL_N_COEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic valid,
    output logic clr,
    output logic acc_en,
    output logic last,
    output logic done
);
    localparam int CNT_W = $clog2(N_COEF);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(N_COEF - 1);

    gll_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = start ? ST_ACCUM : ST_IDLE;
            ST_ACCUM: begin
                if (start)     state_d = ST_ACCUM;
                else if (last) state_d = ST_DONE;
                else           state_d = ST_ACCUM;
            end
            ST_DONE:  state_d = start ? ST_ACCUM : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        clr    = start;
        acc_en = (state_q == ST_ACCUM) && valid && !start;
        last   = acc_en && (cnt_q == CNT_LAST);
        done   = (state_q == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (acc_en) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/gll_lane.sv
module gll_lane
    import gll_pkg::*;
#(
    parameter int COEF_W   = GLL_COEF_W,
    parameter int ACC_W    = GLL_ACC_W,
    parameter int SQ_SHIFT = GLL_SQ_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              acc_en,
    input  logic              last,
    input  logic [COEF_W-1:0] x,
    input  logic [COEF_W-1:0] mu,
    input  logic [COEF_W-1:0] w,
    input  logic [COEF_W-1:0] gconst,
    output logic [ACC_W-1:0]  logp,
    output logic              ovf
);
    localparam int SQF_W  = 2 * COEF_W;
    localparam int SQ_W   = SQF_W - 1 - SQ_SHIFT;
    localparam int PROD_W = SQ_W + COEF_W;

    logic [COEF_W:0]          wide_diff;
    logic                     diff_ovf;
    logic signed [COEF_W-1:0] diff;
    logic signed [SQF_W-1:0]  sq_full;
    logic [SQ_W-1:0]          sq;
    logic [PROD_W-1:0]        prod;
    logic [ACC_W-1:0]         acc_q;
    logic [ACC_W:0]           acc_sum;
    logic                     acc_ovf;
    logic [ACC_W:0]           fin;
    logic                     fin_ovf;
    logic [COEF_W-1:0]        gconst_q;

    always_comb begin
        wide_diff = {x[COEF_W-1], x} - {mu[COEF_W-1], mu};
        diff_ovf  = wide_diff[COEF_W] ^ wide_diff[COEF_W-1];
        diff      = wide_diff[COEF_W-1:0];
        sq_full   = diff * diff;
        sq        = sq_full[SQ_SHIFT +: SQ_W];
        prod      = PROD_W'(sq) * PROD_W'(w);
        acc_sum   = {acc_q[ACC_W-1], acc_q} + {{(ACC_W + 1 - PROD_W){1'b0}}, prod};
        acc_ovf   = acc_sum[ACC_W] ^ acc_sum[ACC_W-1];
        fin       = {{(ACC_W + 1 - COEF_W){gconst_q[COEF_W-1]}}, gconst_q}
                  - {acc_sum[ACC_W-1], acc_sum[ACC_W-1:0]};
        fin_ovf   = fin[ACC_W] ^ fin[ACC_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            ovf      <= 1'b0;
            logp     <= '0;
            gconst_q <= '0;
        end else if (clr) begin
            acc_q    <= '0;
            ovf      <= 1'b0;
            gconst_q <= gconst;
        end else if (acc_en) begin
            acc_q <= acc_sum[ACC_W-1:0];
            ovf   <= ovf | diff_ovf | acc_ovf | (last & fin_ovf);
            if (last) begin
                logp <= fin[ACC_W-1:0];
            end
        end
    end
endmodule

// File: rtl/gll_array.sv
module gll_array
    import gll_pkg::*;
#(
    parameter int COEF_W   = GLL_COEF_W,
    parameter int N_COEF   = GLL_N_COEF,
    parameter int LANES    = GLL_LANES,
    parameter int ACC_W    = GLL_ACC_W,
    parameter int SQ_SHIFT = GLL_SQ_SHIFT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    valid,
    input  logic [LANES*COEF_W-1:0] feat,
    input  logic [COEF_W-1:0]       mean,
    input  logic [COEF_W-1:0]       ivar,
    input  logic [COEF_W-1:0]       gconst,
    output logic [LANES*ACC_W-1:0]  logp,
    output logic                    done,
    output logic [LANES-1:0]        ovf
);
    logic clr, acc_en, last;

    gll_ctrl #(.N_COEF(N_COEF)) ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .valid  (valid),
        .clr    (clr),
        .acc_en (acc_en),
        .last   (last),
        .done   (done)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        gll_lane #(
            .COEF_W   (COEF_W),
            .ACC_W    (ACC_W),
            .SQ_SHIFT (SQ_SHIFT)
        ) lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .acc_en (acc_en),
            .last   (last),
            .x      (feat[k*COEF_W +: COEF_W]),
            .mu     (mean),
            .w      (ivar),
            .gconst (gconst),
            .logp   (logp[k*ACC_W +: ACC_W]),
            .ovf    (ovf[k])
        );
    end
endmodule

// File: rtl/gll_array_chk.sv
module gll_array_chk #(
    parameter int LANES = 8,
    parameter int ACC_W = 52
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   valid,
    input logic [LANES*ACC_W-1:0] logp,
    input logic                   done,
    input logic [LANES-1:0]       ovf
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                            // R3
    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(valid));                                     // R3
    AST_LOGP_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(logp) |-> done);                                   // R3
    AST_NO_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);                                           // R5
    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (ovf == '0));                                     // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ((ovf & $past(ovf)) == $past(ovf)));             // R7
endmodule

bind gll_array gll_array_chk #(.LANES(LANES), .ACC_W(ACC_W)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .valid (valid),
    .logp  (logp),
    .done  (done),
    .ovf   (ovf)
);

// File: tb/gll_array_tb_top.sv
`timescale 1ns/1ps
module gll_array_tb_top;
    localparam int LANES = 8;
    localparam int CW    = 16;
    localparam int AW    = 52;
    localparam int NC    = 26;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic valid = 1'b0;
    logic [LANES*CW-1:0] feat = '0;
    logic [CW-1:0] mean = '0, ivar = '0, gconst = '0;
    logic [LANES*AW-1:0] logp;
    logic done;
    logic [LANES-1:0] ovf;

    int checks = 0;
    int failures = 0;
    int done_seen = 0;
    int pushed = 0;
    bit finished = 0;

    logic [LANES*AW-1:0] exp_logp_q[$];
    logic [LANES-1:0]    exp_ovf_q[$];

    always #2.5 clk = ~clk;

    gll_array dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .valid(valid), .feat(feat),
        .mean(mean), .ivar(ivar), .gconst(gconst), .logp(logp), .done(done), .ovf(ovf)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: compares every done against the oldest expected item
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n && done) begin
            done_seen++;
            if (exp_logp_q.size() == 0) begin
                check(0, "R6", "unexpected done", 1, 0);
            end else begin
                logic [LANES*AW-1:0] el;
                logic [LANES-1:0] eo;
                el = exp_logp_q.pop_front();
                eo = exp_ovf_q.pop_front();
                for (int k = 0; k < LANES; k++)
                    check(logp[k*AW +: AW] == el[k*AW +: AW], "R2", $sformatf("lane %0d logp", k),
                          logp[k*AW +: AW], el[k*AW +: AW]);
                check(ovf == eo, "R7", "ovf vector", AW'(ovf), AW'(eo));
            end
            if (prev_done) check(0, "R3", "done wider than one cycle", 1, 0);
        end
        prev_done = done;
    end

    function automatic int coef_val(int seed, int k, int i);
        return ((seed * 131 + k * 977 + i * 389) % 14001) - 7000;
    endfunction
    function automatic int mean_val(int seed, int i);
        return ((seed * 53 + i * 211) % 8001) - 4000;
    endfunction
    function automatic int wt_val(int seed, int i);
        return (seed * 17 + i * 29 + 3) % 65536;
    endfunction

    // Driver: one full frame; ovf_lane >= 0 forces a range violation on that lane
    task automatic run_frame(input int seed, input bit gaps, input int ovf_lane,
                             input bit start_with_valid);
        int x[LANES][NC];
        int mu[NC];
        int w[NC];
        int g;
        logic [LANES*AW-1:0] el;
        logic [LANES-1:0] eo;
        g = seed * 1000 - 20000;
        for (int i = 0; i < NC; i++) begin
            mu[i] = mean_val(seed, i);
            w[i] = wt_val(seed, i);
            for (int k = 0; k < LANES; k++) x[k][i] = coef_val(seed, k, i);
        end
        if (ovf_lane >= 0) begin
            mu[5] = -25000;
            x[ovf_lane][5] = 32767;
        end
        for (int k = 0; k < LANES; k++) begin
            longint sum = 0;
            eo[k] = 1'b0;
            for (int i = 0; i < NC; i++) begin
                int d = x[k][i] - mu[i];
                shortint d16;
                longint sq;
                if (d > 32767 || d < -32768) eo[k] = 1'b1;
                d16 = shortint'(d);
                sq = (longint'(d16) * longint'(d16)) >>> 5;
                sum += sq * longint'(w[i]);
            end
            el[k*AW +: AW] = AW'(longint'(g) - sum);
        end
        exp_logp_q.push_back(el);
        exp_ovf_q.push_back(eo);
        pushed++;

        @(negedge clk);
        start = 1'b1;
        gconst = CW'(g);
        valid = start_with_valid;
        feat = {LANES{16'h1234}};
        mean = 16'h8000;
        ivar = 16'hFFFF;
        @(negedge clk);
        start = 1'b0;
        gconst = 16'h7FFF;   // R9: must not affect this frame
        for (int i = 0; i < NC; i++) begin
            if (gaps && (i % 3 == 1)) begin
                valid = 1'b0;
                feat = '1;
                @(negedge clk);
            end
            valid = 1'b1;
            mean = CW'(mu[i]);
            ivar = CW'(w[i]);
            for (int k = 0; k < LANES; k++) feat[k*CW +: CW] = CW'(x[k][i]);
            @(negedge clk);
            if (i < NC - 1) check(done == 1'b0, "R3", "done before last coefficient", AW'(done), 0);
        end
        valid = 1'b0;
        check(done == 1'b1, "R3", "done one cycle after 26th coefficient", AW'(done), 1);
        @(negedge clk);
        check(done == 1'b0, "R3", "done drops after one cycle", AW'(done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [LANES*AW-1:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 1'b0, "R1", "done in reset", AW'(done), 0);
        check(ovf == '0, "R1", "ovf in reset", AW'(ovf), 0);
        check(logp == '0, "R1", "logp lane0 in reset", logp[AW-1:0], 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: valid with no frame open
        valid = 1'b1;
        feat = {LANES{16'h4000}};
        repeat (30) begin
            @(negedge clk);
            check(done == 1'b0 && logp == '0, "R6", "idle valid ignored", AW'(done), 0);
        end
        valid = 1'b0;

        // R2, R8, R9: back-to-back frame
        run_frame(1, 1'b0, -1, 1'b0);
        // R4: gaps between coefficients
        run_frame(2, 1'b1, -1, 1'b0);

        // R6: valid after done without start, results held
        held = logp;
        valid = 1'b1;
        repeat (30) begin
            @(negedge clk);
            check(done == 1'b0 && logp == held, "R6", "valid after done ignored", logp[AW-1:0], held[AW-1:0]);
        end
        valid = 1'b0;

        // R5: abort mid-frame, then restart with a valid coefficient on the start cycle
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        valid = 1'b1;
        feat = {LANES{16'h3000}};
        mean = 16'hE000;
        ivar = 16'h7FFF;
        repeat (10) @(negedge clk);
        valid = 1'b0;
        run_frame(3, 1'b0, -1, 1'b1);

        // R7: difference out of range on lane 3 only
        run_frame(4, 1'b1, 3, 1'b0);
        check(ovf == 8'b0000_1000, "R7", "ovf held after frame", AW'(ovf), AW'(8'b0000_1000));
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(ovf == '0, "R7", "ovf cleared by start", AW'(ovf), 0);
        run_frame(5, 1'b0, 6, 1'b0);
        run_frame(6, 1'b1, -1, 1'b0);

        repeat (4) @(negedge clk);
        check(done_seen == pushed, "R3", "done count", AW'(done_seen), AW'(pushed));
        check(exp_logp_q.size() == 0, "R2", "scoreboard drained", AW'(exp_logp_q.size()), 0);
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule